// File: doc/BRIEF.md
# Windowed Keyed Watchdog

This block is a supervision counter that a processor must service by writing a fixed key byte into a trigger register. Servicing is allowed only during a late part of each counting period, the open window. A key that arrives too early, a write of any other byte, or a period that runs out with no valid service each raise a one-cycle internal reset request. The system reset controller consumes that request.

The counting period is a power of two cycles set by a parameter. A 2-bit window selection and a standby-enable configuration bit decide which share of the period, counted back from its end, is open. The first write after reset, and the first write after any reset request, is exempt from the window rule, so start-up software can service the counter at any point. A read of the trigger register returns a constant byte and leaves the counter alone.

Top module: `keyed_window_watchdog`

## Requirements
- R1: Writing the key 0xAC while the counter is at or above the close limit clears the counter to 0 and raises no reset request.
- R2: Writing 0xAC while the counter is below the close limit, once the first write since reset has been taken, raises the reset request.
- R3: With the period P = 2**PERIOD_LOG2 and standby-enable at 1, window select 2'b01 closes counts 0 to P/2-1, 2'b10 closes counts 0 to P/4-1, and 2'b11 closes none.
- R4: Window select 2'b00 behaves as 2'b11, with no closed counts.
- R5: When standby-enable is 0, no count is closed, whatever the window select holds.
- R6: The first 0xAC write after reset release, or after a reset request, is accepted at any count and clears the counter.
- R7: If the counter is at P-1 and no write arrives in that cycle, the reset request is raised. Before that point, idling raises nothing.
- R8: A write of any byte other than 0xAC raises the reset request, whether the window is open or closed and whether or not it is the first write.
- R9: The reset request is high for exactly the one cycle after the clock edge that sampled the fault. After it, the counter is 0 and the next write is again treated as the first.
- R10: With rd_en high, rd_data is 0x9A; otherwise it is 0. A read does not clear or hold the counter.
- R11: During and right after reset, rst_req is low and the counter starts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the trigger register |
| wr_data | input | 8 | Byte written to the trigger register |
| rd_en | input | 1 | Read strobe for the trigger register |
| rd_data | output | 8 | Read value of the trigger register |
| win_sel | input | 2 | Window size selection |
| stby_en | input | 1 | Standby-enable configuration bit; 0 forces a fully open window |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The bench builds the block with PERIOD_LOG2 = 5, a 32-cycle period. That puts the 50% boundary at count 16, the 75% boundary at count 8, and the overflow at count 31 within a few dozen cycles. Every window code and the standby override can therefore be probed on both sides of its boundary, and the overflow can be reached exactly and checked one cycle short of it. The same small period lets the bench confirm that reads leave the counter running all the way to overflow, and that the first-write exemption returns after every kind of reset request.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

   // Window selection codes
   typedef enum logic [1:0] {
      WIN_RSVD = 2'b00,
      WIN_HALF = 2'b01,
      WIN_QTR3 = 2'b10,
      WIN_FULL = 2'b11
   } win_code_t;

   // Outcome of one cycle of trigger-register activity
   typedef enum logic [1:0] {
      EV_IDLE  = 2'b00,
      EV_SERVE = 2'b01,
      EV_FAULT = 2'b10
   } wd_event_t;

   localparam logic [7:0] WD_KEY      = 8'hAC;
   localparam logic [7:0] WD_READBACK = 8'h9A;

endpackage

// File: rtl/wwdt_window_calc.sv
module wwdt_window_calc
   import wwdt_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic [1:0]       win_sel,
   input  logic             stby_en,
   output logic [CNT_W-1:0] close_lim
);

   localparam int          PERIOD = 1 << CNT_W;
   localparam logic [CNT_W:0] P_W = (CNT_W+1)'(PERIOD);

   if (CNT_W < 2) begin : g_bad_width
      $error("wwdt_window_calc: CNT_W must be at least 2");
   end

   win_code_t   code;
   logic [CNT_W:0] open_len;
   logic [CNT_W:0] close_w;

   assign code = win_code_t'(win_sel);

   // open length derived with shifts only
   always_comb begin
      if (!stby_en) begin
         open_len = P_W;
      end else begin
         unique case (code)
            WIN_HALF: open_len = P_W >> 1;
            WIN_QTR3: open_len = (P_W >> 1) + (P_W >> 2);
            WIN_FULL: open_len = P_W;
            default:  open_len = P_W;
         endcase
      end
   end

   assign close_w   = P_W - open_len;
   assign close_lim = close_w[CNT_W-1:0];

endmodule

// File: rtl/wwdt_period_cnt.sv
module wwdt_period_cnt #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   output logic [CNT_W-1:0] count,
   output logic             at_last
);

   localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else begin
         count <= count + 1'b1;
      end
   end

   assign at_last = (count == LAST);

endmodule

// File: rtl/wwdt_key_judge.sv
module wwdt_key_judge
   import wwdt_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             first_seen,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] close_lim,
   input  logic             at_last,
   output wd_event_t        evt
);

   logic key_ok;
   logic in_open;

   assign key_ok  = (wr_data == WD_KEY);
   assign in_open = (count >= close_lim);

   always_comb begin
      evt = EV_IDLE;
      if (wr_en) begin
         if (!key_ok)          evt = EV_FAULT;
         else if (!first_seen) evt = EV_SERVE;
         else if (in_open)     evt = EV_SERVE;
         else                  evt = EV_FAULT;
      end else if (at_last) begin
         evt = EV_FAULT;
      end
   end

endmodule

// File: rtl/keyed_window_watchdog.sv
module keyed_window_watchdog
   import wwdt_pkg::*;
#(
   parameter int PERIOD_LOG2 = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       rd_en,
   output logic [7:0] rd_data,
   input  logic [1:0] win_sel,
   input  logic       stby_en,
   output logic       rst_req
);

   localparam int CNT_W = PERIOD_LOG2;

   if (PERIOD_LOG2 < 2 || PERIOD_LOG2 > 30) begin : g_bad_period
      $error("keyed_window_watchdog: PERIOD_LOG2 out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] close_lim;
   logic             at_last;
   logic             first_q;
   logic             cnt_clear;
   wd_event_t        evt;

   wwdt_window_calc #(.CNT_W(CNT_W)) u_win (
      .win_sel   (win_sel),
      .stby_en   (stby_en),
      .close_lim (close_lim)
   );

   wwdt_key_judge #(.CNT_W(CNT_W)) u_judge (
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .first_seen (first_q),
      .count      (cnt_q),
      .close_lim  (close_lim),
      .at_last    (at_last),
      .evt        (evt)
   );

   assign cnt_clear = (evt != EV_IDLE);

   wwdt_period_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (cnt_clear),
      .count   (cnt_q),
      .at_last (at_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= (evt == EV_FAULT);
         if (evt == EV_SERVE)      first_q <= 1'b1;
         else if (evt == EV_FAULT) first_q <= 1'b0;
      end
   end

   assign rd_data = rd_en ? WD_READBACK : 8'h00;

endmodule

// File: rtl/wwdt_checker.sv
module wwdt_checker #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [7:0]       wr_data,
   input logic             rd_en,
   input logic [7:0]       rd_data,
   input logic             rst_req,
   input logic [CNT_W-1:0] cnt,
   input logic             first_seen,
   input logic [CNT_W-1:0] close_lim
);

   localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

   // R9
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   // R2
   early_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == 8'hAC && first_seen && cnt < close_lim) |=> rst_req);

   // R8
   bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data != 8'hAC) |=> (rst_req && cnt == '0 && !first_seen));

   // R7
   overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && cnt == LAST) |=> rst_req);

   // R1
   serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == 8'hAC && (!first_seen || cnt >= close_lim))
      |=> (!rst_req && cnt == '0 && first_seen));

   // R10
   read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

   // R10
   always_comb begin
      if (rd_en) rd_value_chk: assert (rd_data == 8'h9A);
   end

endmodule

bind keyed_window_watchdog wwdt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .rd_en      (rd_en),
   .rd_data    (rd_data),
   .rst_req    (rst_req),
   .cnt        (cnt_q),
   .first_seen (first_q),
   .close_lim  (close_lim)
);

// File: tb/sim_keyed_window_watchdog.sv
module sim_keyed_window_watchdog;

   localparam int PL2 = 5;
   localparam int P   = 1 << PL2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [1:0] win_sel = 2'b01;
   logic       stby_en = 1'b1;
   logic       rst_req;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   keyed_window_watchdog #(.PERIOD_LOG2(PL2)) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .win_sel (win_sel),
      .stby_en (stby_en),
      .rst_req (rst_req)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // all stimulus changes at negedge
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic expect_req(input bit exp, input string req);
      check(rst_req == exp, req, rst_req, exp);
   endtask

   // leaves counter at 0 with first write taken
   task automatic prime();
      wr(8'hAC);
      expect_req(1'b0, "R6 prime");
   endtask

   // fault pulse, then one idle cycle so state is post-reset again
   task automatic expect_pulse(input string req);
      expect_req(1'b1, req);
      @(negedge clk);
      check(rst_req == 1'b0, "R9 pulse width", rst_req, 0);
      // counter now 1 after the extra cycle, first flag cleared
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      check(rst_req == 1'b0, "R11 reset req low", rst_req, 0);
      rd_en = 1'b1; #1;
      check(rd_data == 8'h9A, "R10 read value", rd_data, 8'h9A);
      rd_en = 1'b0; #1;
      check(rd_data == 8'h00, "R10 read idle value", rd_data, 0);
   endtask

   task automatic t_first_and_early();
      win_sel = 2'b01; stby_en = 1'b1;
      do_reset();
      idle(2);
      wr(8'hAC);                     // first write at count 2, closed area
      expect_req(1'b0, "R6 first write any time");
      idle(5);
      wr(8'hAC);                     // count 5 < 16
      expect_pulse("R2 early key 50%");
   endtask

   task automatic t_half_edges();
      win_sel = 2'b01; stby_en = 1'b1;
      do_reset();
      prime();
      idle(15); wr(8'hAC);           // count 15
      expect_pulse("R3 50% count 15 closed");
      prime();
      idle(16); wr(8'hAC);           // count 16
      expect_req(1'b0, "R1 50% count 16 open");
      idle(31); wr(8'hAC);           // count 31
      expect_req(1'b0, "R1 serve at last count");
   endtask

   task automatic t_quarter();
      win_sel = 2'b10; stby_en = 1'b1;
      do_reset();
      prime();
      idle(7); wr(8'hAC);
      expect_pulse("R3 75% count 7 closed");
      prime();
      idle(8); wr(8'hAC);
      expect_req(1'b0, "R3 75% count 8 open");
   endtask

   task automatic t_full_codes();
      do_reset();
      win_sel = 2'b11; stby_en = 1'b1;
      prime();
      wr(8'hAC);
      expect_req(1'b0, "R3 code 11 count 0 open");
      win_sel = 2'b00;
      idle(1); wr(8'hAC);
      expect_req(1'b0, "R4 code 00 count 1 open");
      win_sel = 2'b01; stby_en = 1'b0;
      idle(1); wr(8'hAC);
      expect_req(1'b0, "R5 standby off count 1 open");
      win_sel = 2'b10;
      wr(8'hAC);
      expect_req(1'b0, "R5 standby off count 0 open");
      stby_en = 1'b1;
   endtask

   task automatic t_bad_key();
      win_sel = 2'b01; stby_en = 1'b1;
      do_reset();
      wr(8'h55);                     // first write, wrong byte
      expect_pulse("R8 wrong key as first write");
      prime();
      idle(20); wr(8'hAB);           // open window, wrong byte
      expect_pulse("R8 wrong key in open window");
   endtask

   task automatic t_overflow_and_read();
      win_sel = 2'b01; stby_en = 1'b1;
      do_reset();
      prime();
      rd_en = 1'b1;
      idle(P-1);                     // counter at P-1
      check(rst_req == 1'b0, "R7 no request before overflow", rst_req, 0);
      check(rd_data == 8'h9A, "R10 read value while counting", rd_data, 8'h9A);
      idle(1);
      check(rst_req == 1'b1, "R7 overflow with reads (R10)", rst_req, 1);
      rd_en = 1'b0;
      idle(1);
      check(rst_req == 1'b0, "R9 overflow pulse width", rst_req, 0);
      idle(2); wr(8'hAC);            // first-write rule restored: count 3
      expect_req(1'b0, "R9 first flag cleared after request");
   endtask

   initial begin
      t_reset();
      t_first_and_early();
      t_half_edges();
      t_quarter();
      t_full_codes();
      t_bad_key();
      t_overflow_and_read();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog timeout actual=0 expected=1");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule